// File: doc/BRIEF.md
# I2C Addressed Target Controller

This block is the target (responder) side of an I2C bus. It takes the raw SCL and SDA pins and passes them through a synchronizer. From the synchronized values it finds start and stop conditions and bit edges. It can only pull SDA low, through an open-drain enable. After a start, the first byte names a 7-bit target address and a direction bit. When the address equals `addr_i`, the block acknowledges and runs byte transfers in the requested direction until a stop or another start.

User logic sees one-cycle pulses for start, stop, byte received (`write_o`, with the byte on `rx_byte_o`) and byte needed (`read_o`). The user's answer to a strobe is taken combinationally in the strobe cycle itself:
- During `write_o`, `wack_i` decides whether the received byte is acknowledged.
- During `read_o`, `tx_byte_i` is loaded as the next byte to transmit.

The block never stretches SCL. It supports neither 10-bit addressing nor general call.

Top module: `i2c_target_ctrl`

## Requirements
- R1: After reset, `sda_oe_o` is 0 and `start_o`, `stop_o`, `write_o` and `read_o` are all 0.
- R2: A falling SDA while SCL is high gives a one-cycle `start_o` and restarts address reception from any state, including in the middle of a transfer (repeated start). SDA is released in the following cycle.
- R3: A rising SDA while SCL is high gives a one-cycle `stop_o`, releases SDA and returns the block to idle. Bytes clocked afterwards without a new start are neither acknowledged nor strobed.
- R4: The first byte after a start is received most significant bit first. Bits 7..1 are the address and bit 0 is the direction (1 = read, 0 = write). If bits 7..1 equal `addr_i`, SDA is held low for the whole ninth clock.
- R5: If the address does not match, SDA stays released through the ninth clock and for the rest of the transfer. No `write_o` or `read_o` occurs until the next start.
- R6: In a write transfer, each data byte is received MSB first. At the SCL fall that ends its eighth bit, `write_o` pulses for one cycle and `rx_byte_o` holds the byte.
- R7: `wack_i` is sampled in the cycle `write_o` is high. A value of 1 holds SDA low for the ninth clock (acknowledge); 0 leaves SDA released (not-acknowledge).
- R8: In a read transfer, `read_o` pulses for one cycle in two places: at the SCL fall that ends the address acknowledge, and at the SCL fall that ends every read acknowledge in which the initiator drove SDA low. `tx_byte_i` is loaded in that same cycle.
- R9: Read bytes are driven MSB first with SDA released during the ninth clock. If the initiator leaves SDA high in that clock (not-acknowledge), no further `read_o` occurs and SDA stays released until the next start.
- R10: At most one of `start_o`, `stop_o`, `write_o`, `read_o` is high in any cycle. The SDA drive changes only while the synchronized SCL is low, or as the release that follows a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| addr_i | input | 7 | Own target address |
| start_o | output | 1 | Start condition pulse |
| stop_o | output | 1 | Stop condition pulse |
| write_o | output | 1 | Received byte strobe |
| rx_byte_o | output | 8 | Received byte, valid with `write_o` |
| wack_i | input | 1 | Acknowledge choice, sampled with `write_o` |
| read_o | output | 1 | Transmit byte request strobe |
| tx_byte_i | input | 8 | Byte to transmit, sampled with `read_o` |

## Verification
Two things fall in the same cycle and are checked together:
- Each strobe and the sampling of the user's answer to it: `write_o` with `wack_i`, and `read_o` with `tx_byte_i`.

To provoke this, the bench drives `wack_i` and `tx_byte_i` through combinational muxes on the strobes. They present the intended value only while the strobe is high and the inverted value in every other cycle. A design that samples a cycle early or late therefore acknowledges wrongly or sends the complemented byte. The bench sees this at the bus as a wrong ninth bit or a wrong read byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_p_q, sda_p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_s_i;
      sda_p_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_p_q;
  assign scl_fall_o = ~scl_s_i & scl_p_q;
  // conditions only while SCL is stable high
  assign start_o = scl_s_i & scl_p_q & sda_p_q & ~sda_s_i;
  assign stop_o  = scl_s_i & scl_p_q & ~sda_p_q & sda_s_i;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DATA_W-2:0] addr_i,
  input  logic              wack_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              write_o,
  output logic              read_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              sda_low_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  tgt_state_e        state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic              rw_q, nak_q, sda_low_q;
  logic              addr_hit;

  assign addr_hit  = (shreg_q[DATA_W-1:1] == addr_i);
  assign write_o   = scl_fall_i && (state_q == ST_WR) && (bitcnt_q == CNT_FULL);
  assign read_o    = scl_fall_i && (((state_q == ST_ADDR_ACK) && rw_q) ||
                                    ((state_q == ST_RD_ACK) && !nak_q));
  assign rx_byte_o = shreg_q;
  assign sda_low_o = sda_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shreg_q   <= '0;
      bitcnt_q  <= '0;
      rw_q      <= 1'b0;
      nak_q     <= 1'b0;
      sda_low_q <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_ADDR;
      bitcnt_q  <= '0;
      sda_low_q <= 1'b0;
    end else if (stop_i) begin
      state_q   <= ST_IDLE;
      sda_low_q <= 1'b0;
    end else if (read_o) begin
      // user byte taken in the strobe cycle
      state_q   <= ST_RD;
      shreg_q   <= tx_byte_i;
      sda_low_q <= ~tx_byte_i[DATA_W-1];
      bitcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise_i && bitcnt_q < CNT_FULL) begin
            shreg_q  <= {shreg_q[DATA_W-2:0], sda_s_i};
            bitcnt_q <= bitcnt_q + 1'b1;
          end else if (scl_fall_i && bitcnt_q == CNT_FULL) begin
            bitcnt_q <= '0;
            if (state_q == ST_WR) begin
              state_q   <= ST_WR_ACK;
              sda_low_q <= wack_i;
            end else if (addr_hit) begin
              state_q   <= ST_ADDR_ACK;
              rw_q      <= shreg_q[0];
              sda_low_q <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK, ST_WR_ACK: begin
          // read direction leaves ADDR_ACK through read_o above
          if (scl_fall_i) begin
            state_q   <= ST_WR;
            sda_low_q <= 1'b0;
            bitcnt_q  <= '0;
          end
        end
        ST_RD: begin
          if (scl_fall_i) begin
            if (bitcnt_q == CNT_LAST) begin
              state_q   <= ST_RD_ACK;
              sda_low_q <= 1'b0;
              bitcnt_q  <= '0;
            end else begin
              shreg_q   <= {shreg_q[DATA_W-2:0], 1'b0};
              sda_low_q <= ~shreg_q[DATA_W-2];
              bitcnt_q  <= bitcnt_q + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) nak_q <= sda_s_i;
          else if (scl_fall_i) state_q <= ST_IDLE;  // only reached on NAK
        end
        default: begin
          state_q   <= ST_IDLE;
          sda_low_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [DATA_W-2:0] addr_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              write_o,
  output logic [DATA_W-1:0] rx_byte_o,
  input  logic              wack_i,
  output logic              read_o,
  input  logic [DATA_W-1:0] tx_byte_i
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] pin_raw, pin_sync;
  logic scl_s, sda_s, scl_rise, scl_fall;

  assign pin_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_raw[g]),
      .q_o   (pin_sync[g])
    );
  end

  assign scl_s = pin_sync[0];
  assign sda_s = pin_sync[1];

  i2c_tgt_cond i_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_o),
    .stop_o    (stop_o)
  );

  i2c_tgt_fsm #(.DATA_W(DATA_W)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_s_i   (sda_s),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_o),
    .stop_i    (stop_o),
    .addr_i    (addr_i),
    .wack_i    (wack_i),
    .tx_byte_i (tx_byte_i),
    .write_o   (write_o),
    .read_o    (read_o),
    .rx_byte_o (rx_byte_o),
    .sda_low_o (sda_oe_o)
  );
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic sda_oe_o,
  input logic start_o,
  input logic stop_o,
  input logic write_o,
  input logic read_o,
  input logic wack_i,
  input logic tx_msb_i
);
  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o, write_o, read_o}));

  assert_sda_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> (!$past(scl_s) || $past(start_o) || $past(stop_o)));

  assert_start_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !sda_oe_o);

  assert_stop_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !sda_oe_o);

  assert_write_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_o |=> !write_o);

  assert_write_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_o |=> (sda_oe_o == $past(wack_i)));

  assert_read_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_o |=> (sda_oe_o == !$past(tx_msb_i)));
endmodule

bind i2c_target_ctrl i2c_tgt_checker i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_s   (scl_s),
  .sda_oe_o(sda_oe_o),
  .start_o (start_o),
  .stop_o  (stop_o),
  .write_o (write_o),
  .read_o  (read_o),
  .wack_i  (wack_i),
  .tx_msb_i(tx_byte_i[DATA_W-1])
);

// File: tb/test_i2c_target_ctrl.sv
module test_i2c_target_ctrl;
  localparam int Q = 5;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, start_p, stop_p, write_p, read_p;
  logic [7:0] rx_byte, tx_data = 8'h00, tx_mux;
  logic want_ack = 1'b1, wack_mux;
  wire sda_line = sda_m & ~sda_oe;

  int n_checks = 0, n_errs = 0;
  int cnt_start = 0, cnt_stop = 0, cnt_wr = 0, cnt_rd = 0;
  logic [7:0] last_rx = 8'h00;

  always #5 clk = ~clk;

  // user answer is valid only in the strobe cycle
  assign tx_mux   = read_p  ? tx_data  : ~tx_data;
  assign wack_mux = write_p ? want_ack : ~want_ack;

  i2c_target_ctrl i_i2c_target_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_i(OWN), .start_o(start_p), .stop_o(stop_p),
    .write_o(write_p), .rx_byte_o(rx_byte), .wack_i(wack_mux),
    .read_o(read_p), .tx_byte_i(tx_mux)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_p) cnt_start++;
      if (stop_p)  cnt_stop++;
      if (read_p)  cnt_rd++;
      if (write_p) begin cnt_wr++; last_rx = rx_byte; end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    wait_n(Q); sda_m = b;
    wait_n(Q); scl_m = 1'b1;
    wait_n(Q); s = sda_line;
    wait_n(Q); scl_m = 1'b0;
  endtask

  task automatic do_start();
    if (!scl_m) begin
      wait_n(Q); sda_m = 1'b1;
      wait_n(Q); scl_m = 1'b1;
    end
    wait_n(Q); sda_m = 1'b0;
    wait_n(Q); scl_m = 1'b0;
  endtask

  task automatic do_stop();
    wait_n(Q); sda_m = 1'b0;
    wait_n(Q); scl_m = 1'b1;
    wait_n(Q); sda_m = 1'b1;
    wait_n(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackb);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, ackb);
  endtask

  // one transfer; d holds up to 4 bytes, byte k at d[8k+:8]
  task automatic txn(input logic [6:0] a, input logic rw, input int n,
                     input logic [31:0] d, input logic [3:0] acks, input logic fin);
    logic ab, s;
    logic [7:0] got;
    int st0, wr0, rd0;
    logic hit;
    hit = (a == OWN);
    st0 = cnt_start;
    do_start();
    check("R2 start pulse", cnt_start - st0, 1);
    tx_data = d[7:0];
    wr0 = cnt_wr; rd0 = cnt_rd;
    send_byte({a, rw}, ab);
    check(hit ? "R4 address ack" : "R5 no address ack", ab, hit ? 0 : 1);
    for (int k = 0; k < n; k++) begin
      if (!rw) begin
        want_ack = acks[k];
        send_byte(d[8*k +: 8], ab);
        check("R7 write ack bit", ab, hit ? !acks[k] : 1);
        check(hit ? "R6 write strobe" : "R5 no write strobe", cnt_wr - wr0, hit ? k + 1 : 0);
        if (hit) check("R6 received byte", last_rx, d[8*k +: 8]);
      end else begin
        for (int i = 7; i >= 0; i--) begin bit_xfer(1'b1, s); got[i] = s; end
        check(hit ? "R9 read byte" : "R5 released read", got, hit ? d[8*k +: 8] : 8'hFF);
        if (k + 1 < 4) tx_data = d[8*(k+1) +: 8];
        bit_xfer(k == n - 1, s);
      end
    end
    if (rw) begin
      wait_n(Q);
      check(hit ? "R8 read strobes" : "R5 no read strobe", cnt_rd - rd0, hit ? n : 0);
      check("R9 released after nak", sda_oe, 0);
    end
    if (fin) begin
      st0 = cnt_stop;
      do_stop();
      check("R3 stop pulse", cnt_stop - st0, 1);
      check("R3 sda released", sda_oe, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    logic ab;
    int wr0;
    void'($urandom(32'd1234));
    wait_n(3);
    check("R1 sda released", sda_oe, 0);
    check("R1 strobes idle", {start_p, stop_p, write_p, read_p}, 0);
    rst_n = 1'b1;
    wait_n(4);
    // directed
    txn(OWN, 1'b0, 1, 32'h000000A5, 4'b0001, 1'b1);
    txn(OWN, 1'b0, 2, 32'h00005A3C, 4'b0010, 1'b1);
    txn(OWN, 1'b1, 3, 32'h00C35A81, 4'b0000, 1'b1);
    txn(OWN ^ 7'h01, 1'b0, 2, 32'h0000FF00, 4'b0011, 1'b1);
    txn(OWN ^ 7'h40, 1'b1, 2, 32'h00000011, 4'b0000, 1'b1);
    // repeated start: write then read without stop between
    txn(OWN, 1'b0, 1, 32'h00000077, 4'b0001, 1'b0);
    txn(OWN, 1'b1, 1, 32'h00000000, 4'b0000, 1'b1);
    // after stop, byte clocked without start is ignored
    wr0 = cnt_wr;
    scl_m = 1'b0;
    send_byte({OWN, 1'b0}, ab);
    check("R3 idle no ack", ab, 1);
    send_byte(8'h12, ab);
    check("R3 idle no write", cnt_wr - wr0, 0);
    // random
    for (int t = 0; t < 30; t++) begin
      logic [6:0] a;
      a = ($urandom % 3 == 0) ? 7'($urandom) : OWN;
      txn(a, 1'($urandom), 1 + int'($urandom % 4), $urandom, 4'($urandom),
          ($urandom % 4) != 0);
    end
    do_stop();
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule